// File: doc/BRIEF.md
# Raster-Operation Pixel Combiner

This block produces the result pixel for one destination location of a block transfer. Each accepted beat carries a source pixel, a pattern pixel and the pixel already in the destination. An 8-bit ternary raster-operation code combines the three pixels bit by bit. The code can express any of the 256 possible functions of pattern, source and destination.

Before the combine step, the source and the pattern can each be widened from a single monochrome bit to a full colour pixel. The foreground and background colour inputs supply the colours. The source can also be replaced by the foreground colour to give solid fills, and the pattern can be replaced by it to give a solid brush. When the background mode is transparent, a monochrome 0 bit marks the pixel as untouched. The block then drops the write-enable and passes the destination through unchanged.

The surrounding engine supplies one beat per cycle with a valid strobe and writes the result back whenever the write-enable is high. Address generation, pattern fetch and memory traffic all sit outside this block.

Top module: `rop_pixel_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `valid_o`, `we_o` and `pix_o` are all zero.
- R2: The result takes one cycle. When `valid_i` is sampled high at a clock edge, `valid_o` is high after that edge. When `valid_i` is sampled low, `valid_o` is low after the edge.
- R3: Result bit i is bit `{p[i],s[i],d[i]}` of `rop_i`, with the pattern bit as the most significant index bit. So 0xF0 copies the pattern, 0xCC copies the source, 0xAA keeps the destination, 0x5A gives pattern XOR destination, 0x00 gives all zeros and 0xFF gives all ones.
- R4: With `src_mono_i`=1 and `src_solid_i`=0, the source operand is taken from `src_bit_i`. A 1 bit selects `fg_i[PIX_W-1:0]`. A 0 bit selects `bg_i[PIX_W-1:0]` when `transp_i`=0. In this mode `src_i` has no effect.
- R5: With `pat_mono_i`=1 and `brush_solid_i`=0, the pattern operand is taken from `pat_bit_i`. A 1 bit selects the foreground colour. A 0 bit selects the background colour when `transp_i`=0. In this mode `pat_i` has no effect.
- R6: A pixel is transparent when `transp_i`=1 and an active monochrome operand (source or pattern) has a 0 bit. For a transparent pixel, `we_o` is 0 and `pix_o` equals the `dst_i` of that beat.
- R7: With `src_solid_i`=1, the source operand is `fg_i[PIX_W-1:0]`, whatever `src_i`, `src_bit_i` and `src_mono_i` hold.
- R8: With `brush_solid_i`=1, the pattern operand is `fg_i[PIX_W-1:0]`, whatever `pat_i`, `pat_bit_i` and `pat_mono_i` hold.
- R9: `we_o` is 1 after an accepted beat that is not transparent. `we_o` is never 1 while `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Beat strobe |
| src_i | input | PIX_W | Colour source pixel |
| src_bit_i | input | 1 | Monochrome source bit |
| pat_i | input | PIX_W | Colour pattern pixel |
| pat_bit_i | input | 1 | Monochrome pattern bit |
| dst_i | input | PIX_W | Existing destination pixel |
| rop_i | input | 8 | Ternary raster-operation code |
| fg_i | input | 16 | Foreground colour (low PIX_W bits used) |
| bg_i | input | 16 | Background colour (low PIX_W bits used) |
| transp_i | input | 1 | 1 = transparent background, 0 = opaque |
| src_mono_i | input | 1 | Source is monochrome |
| pat_mono_i | input | 1 | Pattern is monochrome |
| src_solid_i | input | 1 | Replace source with foreground colour |
| brush_solid_i | input | 1 | Replace pattern with foreground colour |
| valid_o | output | 1 | Result valid |
| pix_o | output | PIX_W | Result pixel |
| we_o | output | 1 | Write-enable for the result |

## Verification
The assertions check several properties on every cycle. They check the one-cycle valid pipeline and that the write-enable stays low without a valid result. They check that a transparent beat returns its destination with writes held off. They also check that the pure source-copy and pattern-copy codes deliver the foreground colour under a solid source or a solid brush. Only the bench's scenarios can show the behaviour across all 256 codes, the opaque expansion of 0 and 1 bits, and that colour inputs are ignored in monochrome and solid modes. The bench covers these with directed codes and a seeded random sweep that is checked against a reference function.

// File: rtl/rop_pkg.sv
`timescale 1ns/1ps
package rop_pkg;
  localparam int COLOR_W = 16;
  localparam int ROP_W   = 8;
  typedef logic [ROP_W-1:0]   rop_code_t;
  typedef logic [COLOR_W-1:0] color_t;
endpackage

// File: rtl/rop_expand.sv
`timescale 1ns/1ps
// Operand selection: colour pixel, monochrome expansion, or solid foreground.
module rop_expand import rop_pkg::*; #(
  parameter int PIX_W = 16
) (
  input  logic [PIX_W-1:0] color_i,
  input  logic             bit_i,
  input  logic             mono_i,
  input  logic             solid_i,
  input  logic             transp_i,
  input  color_t           fg_i,
  input  color_t           bg_i,
  output logic [PIX_W-1:0] op_o,
  output logic             hide_o
);
  logic [PIX_W-1:0] fg_w, bg_w;
  logic             expand;

  assign fg_w   = fg_i[PIX_W-1:0];
  assign bg_w   = bg_i[PIX_W-1:0];
  assign expand = mono_i && !solid_i;

  always_comb begin
    if (solid_i)     op_o = fg_w;
    else if (mono_i) op_o = bit_i ? fg_w : bg_w;
    else             op_o = color_i;
  end

  assign hide_o = expand && transp_i && !bit_i;
endmodule

// File: rtl/rop_ternary.sv
`timescale 1ns/1ps
// Per-bit 8:1 lookup of the raster-operation code.
module rop_ternary import rop_pkg::*; #(
  parameter int PIX_W = 16
) (
  input  rop_code_t        rop_i,
  input  logic [PIX_W-1:0] pat_i,
  input  logic [PIX_W-1:0] src_i,
  input  logic [PIX_W-1:0] dst_i,
  output logic [PIX_W-1:0] res_o
);
  for (genvar g = 0; g < PIX_W; g++) begin : g_bit
    logic [2:0] sel;
    assign sel      = {pat_i[g], src_i[g], dst_i[g]};
    assign res_o[g] = rop_i[sel];
  end
endmodule

// File: rtl/rop_pixel_unit.sv
`timescale 1ns/1ps
module rop_pixel_unit import rop_pkg::*; #(
  parameter int PIX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PIX_W-1:0] src_i,
  input  logic             src_bit_i,
  input  logic [PIX_W-1:0] pat_i,
  input  logic             pat_bit_i,
  input  logic [PIX_W-1:0] dst_i,
  input  logic [7:0]       rop_i,
  input  logic [15:0]      fg_i,
  input  logic [15:0]      bg_i,
  input  logic             transp_i,
  input  logic             src_mono_i,
  input  logic             pat_mono_i,
  input  logic             src_solid_i,
  input  logic             brush_solid_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             we_o
);
  logic [PIX_W-1:0] src_op, pat_op, rop_res;
  logic             src_hide, pat_hide, hide;

  rop_expand #(.PIX_W(PIX_W)) u_src_exp (
    .color_i (src_i),
    .bit_i   (src_bit_i),
    .mono_i  (src_mono_i),
    .solid_i (src_solid_i),
    .transp_i(transp_i),
    .fg_i    (fg_i),
    .bg_i    (bg_i),
    .op_o    (src_op),
    .hide_o  (src_hide)
  );

  rop_expand #(.PIX_W(PIX_W)) u_pat_exp (
    .color_i (pat_i),
    .bit_i   (pat_bit_i),
    .mono_i  (pat_mono_i),
    .solid_i (brush_solid_i),
    .transp_i(transp_i),
    .fg_i    (fg_i),
    .bg_i    (bg_i),
    .op_o    (pat_op),
    .hide_o  (pat_hide)
  );

  rop_ternary #(.PIX_W(PIX_W)) u_rop (
    .rop_i(rop_i),
    .pat_i(pat_op),
    .src_i(src_op),
    .dst_i(dst_i),
    .res_o(rop_res)
  );

  assign hide = src_hide || pat_hide;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      we_o    <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      we_o    <= valid_i && !hide;
      if (valid_i) pix_o <= hide ? dst_i : rop_res;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  we_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !we_o);
  // R6
  transp_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hide) |=> (!we_o && pix_o == $past(dst_i)));
  // R7
  solid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_solid_i && rop_i == 8'hCC && !pat_hide)
      |=> (we_o && pix_o == $past(fg_i[PIX_W-1:0])));
  // R8
  solid_brush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && brush_solid_i && rop_i == 8'hF0 && !src_hide)
      |=> (we_o && pix_o == $past(fg_i[PIX_W-1:0])));
endmodule

// File: tb/sim_rop_pixel_unit.sv
`timescale 1ns/1ps
module sim_rop_pixel_unit;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          valid, src_bit, pat_bit, transp, src_mono, pat_mono, src_solid, brush;
  logic [PW-1:0] src, pat, dst;
  logic [7:0]    rop;
  logic [15:0]   fg, bg;
  logic          valid_o, we_o;
  logic [PW-1:0] pix_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  rop_pixel_unit #(.PIX_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid),
    .src_i(src), .src_bit_i(src_bit), .pat_i(pat), .pat_bit_i(pat_bit),
    .dst_i(dst), .rop_i(rop), .fg_i(fg), .bg_i(bg), .transp_i(transp),
    .src_mono_i(src_mono), .pat_mono_i(pat_mono),
    .src_solid_i(src_solid), .brush_solid_i(brush_solid_i_w),
    .valid_o(valid_o), .pix_o(pix_o), .we_o(we_o)
  );
  wire brush_solid_i_w = brush;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: returns {we, pixel}
  function automatic logic [PW:0] model();
    logic [PW-1:0] s, p, r;
    logic hid;
    s = src_solid ? fg[PW-1:0] : (src_mono ? (src_bit ? fg[PW-1:0] : bg[PW-1:0]) : src);
    p = brush ? fg[PW-1:0] : (pat_mono ? (pat_bit ? fg[PW-1:0] : bg[PW-1:0]) : pat);
    hid = transp && ((src_mono && !src_solid && !src_bit) || (pat_mono && !brush && !pat_bit));
    for (int i = 0; i < PW; i++) r[i] = rop[{p[i], s[i], dst[i]}];
    return hid ? {1'b0, dst} : {1'b1, r};
  endfunction

  task automatic clr_modes();
    transp = 0; src_mono = 0; pat_mono = 0; src_solid = 0; brush = 0;
    src_bit = 0; pat_bit = 0;
  endtask

  // Drive one beat at negedge, sample just after the capturing edge.
  task automatic beat(input string req, input bit use_exp, input logic [PW-1:0] exp_pix, input bit exp_we);
    logic [PW:0] m;
    @(negedge clk);
    valid = 1;
    m = model();
    if (!use_exp) begin exp_pix = m[PW-1:0]; exp_we = m[PW]; end
    @(posedge clk); #1;
    chk(valid_o === 1'b1, req, {31'b0, valid_o}, 32'd1);
    chk(pix_o === exp_pix, req, {16'b0, pix_o}, {16'b0, exp_pix});
    chk(we_o === exp_we, req, {31'b0, we_o}, {31'b0, exp_we});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    valid = 0; src = '0; pat = '0; dst = '0; rop = '0; fg = '0; bg = '0;
    clr_modes();
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs during reset
    chk(valid_o === 1'b0 && we_o === 1'b0 && pix_o === '0, "R1", {14'b0, valid_o, we_o, pix_o}, 32'd0);
    @(negedge clk); rst_ni = 1;
    @(posedge clk); #1;
    chk(valid_o === 1'b0 && we_o === 1'b0, "R1", {30'b0, valid_o, we_o}, 32'd0);

    // R3 directed codes
    src = 16'h1234; pat = 16'hA5C3; dst = 16'h0FF0;
    rop = 8'hCC; beat("R3 copy src", 1, 16'h1234, 1);
    rop = 8'hF0; beat("R3 copy pat", 1, 16'hA5C3, 1);
    rop = 8'hAA; beat("R3 keep dst", 1, 16'h0FF0, 1);
    rop = 8'h5A; beat("R3 pat^dst", 1, 16'hAA33, 1);
    rop = 8'h00; beat("R3 zero", 1, 16'h0000, 1);
    rop = 8'hFF; beat("R3 ones", 1, 16'hFFFF, 1);
    rop = 8'h88; beat("R3 src&dst", 1, 16'h0230, 1);

    // R2: idle beat leaves valid_o and we_o low
    @(negedge clk); valid = 0;
    @(posedge clk); #1;
    chk(valid_o === 1'b0, "R2", {31'b0, valid_o}, 32'd0);
    // R9: no write without a valid result
    chk(we_o === 1'b0, "R9", {31'b0, we_o}, 32'd0);

    fg = 16'hBEEF; bg = 16'h1357;
    // R4 opaque source expansion; src_i ignored
    clr_modes(); rop = 8'hCC; src = 16'hFFFF; src_mono = 1;
    src_bit = 1; beat("R4 fg", 1, 16'hBEEF, 1);
    src_bit = 0; beat("R4 bg", 1, 16'h1357, 1);
    // R5 opaque pattern expansion; pat_i ignored
    clr_modes(); rop = 8'hF0; pat = 16'h0000; pat_mono = 1;
    pat_bit = 1; beat("R5 fg", 1, 16'hBEEF, 1);
    pat_bit = 0; beat("R5 bg", 1, 16'h1357, 1);
    // R6 transparent: destination passes, write held off
    transp = 1; dst = 16'h4242; beat("R6 pat", 1, 16'h4242, 0);
    clr_modes(); transp = 1; src_mono = 1; src_bit = 0; rop = 8'hCC; dst = 16'h7777;
    beat("R6 src", 1, 16'h7777, 0);
    // R9: transparent 1 bit still writes
    src_bit = 1; beat("R9 transp fg", 1, 16'hBEEF, 1);
    // R7 solid source overrides mono and colour
    clr_modes(); src_solid = 1; src_mono = 1; src_bit = 0; transp = 1; src = 16'h0001; rop = 8'hCC;
    beat("R7", 1, 16'hBEEF, 1);
    // R8 solid brush overrides mono pattern
    clr_modes(); brush = 1; pat_mono = 1; pat_bit = 0; transp = 1; pat = 16'h0002; rop = 8'hF0;
    beat("R8", 1, 16'hBEEF, 1);

    // Random sweep against reference
    for (int k = 0; k < 400; k++) begin
      src = 16'($urandom); pat = 16'($urandom); dst = 16'($urandom);
      rop = 8'($urandom); fg = 16'($urandom); bg = 16'($urandom);
      {transp, src_mono, pat_mono, src_solid, brush, src_bit, pat_bit} = 7'($urandom);
      beat("R3 R4 R5 R6 R7 R8 random", 0, '0, 0);
    end

    @(negedge clk); valid = 0;
    @(posedge clk); #1;
    chk(valid_o === 1'b0 && we_o === 1'b0, "R2 R9 tail", {30'b0, valid_o, we_o}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule